// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Global Invalidate

This block caches virtual-page to physical-page translations in a small set of entries that are all searched at once. A lookup presents a virtual page number and an access type. In the same cycle, without a clock edge, the block reports one of three results: a usable translation with its physical page, a protection fault, or a miss. Each entry carries a permission bit. A write that lands on a page marked read-only raises a fault and is not reported as a hit.

When a lookup misses, the translation is installed through the fill port. The fill logic picks a destination entry in a fixed order. An entry that already holds the same virtual page is used first. If there is none, the lowest-numbered empty entry is used. Failing both, the lowest-numbered entry whose referenced bit is clear is used. This gives an approximation of least-recently-used replacement at the cost of one bit per entry. A flush input clears every entry at once, as needed on a context switch. Flush overrides a fill that arrives in the same cycle.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup whose page number equals that of any valid entry returns that entry's physical page on `lk_ppn` in the same cycle, whatever the entry's position.
- R2: A lookup that matches no valid entry drives `lk_hit`=0, `lk_fault`=0 and `lk_ppn`=0.
- R3: Each entry's permission bit is 1 for read/write and 0 for read-only. A matching lookup with `lk_write`=1 on a read-only entry gives `lk_fault`=1 and `lk_hit`=0. Every other matching lookup gives `lk_hit`=1 and `lk_fault`=0.
- R4: A fill whose page number matches no valid entry, while some entry is invalid, writes the lowest-indexed invalid entry and makes it valid at the next edge.
- R5: A fill whose page number matches no valid entry, while all entries are valid, replaces the lowest-indexed entry whose referenced bit is clear. An entry's referenced bit is set at the edge after a lookup with `lk_req`=1 matches it (fault or hit), and at the edge after a fill writes it.
- R6: When the updated set of referenced bits would have every bit at 1, all referenced bits are cleared at that edge instead.
- R7: A fill whose page number matches a valid entry overwrites that entry's physical page and permission, so no two valid entries ever hold the same page number.
- R8: `flush`=1 invalidates every entry and clears every referenced bit at the next edge. A fill or lookup in the same cycle has no effect on the contents.
- R9: After reset all entries are invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup is real, so a matching entry is marked referenced |
| lk_write | input | 1 | Lookup access type: 1 write, 0 read |
| lk_vpn | input | VPN_W | Virtual page number being translated |
| lk_hit | output | 1 | Permitted translation found |
| lk_fault | output | 1 | Write to a read-only page |
| lk_ppn | output | PPN_W | Physical page of the matching entry, 0 on miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | VPN_W | Virtual page number to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_rw | input | 1 | Permission of the new entry: 1 read/write, 0 read-only |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with 8 entries and 8-bit page numbers, and draws lookup and fill page numbers from only 16 values. At that size the buffer fills within a few operations, and random fills often collide with live entries. Overwrite, the full-buffer victim choice and the clearing of the referenced bits then occur many times per run rather than seldom. A reference model written from the requirements predicts every lookup result, so a wrong eviction shows up as a later hit or miss that differs from the model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,
    SLOT_FREE  = 2'd1,
    SLOT_OLD   = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0][VPN_W-1:0]   tag_tab,
  input  logic [ENTRIES-1:0]              live,
  input  logic [VPN_W-1:0]                key,
  output logic [ENTRIES-1:0]              match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live[g] && (tag_tab[g] == key);
  end

  // R7: unique tags keep the parallel compare free of double matches
  p_unique_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] same_tag,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] refd,
  output logic [ENTRIES-1:0] sel,
  output slot_kind_e         kind
);
  logic [ENTRIES-1:0] free_v, old_v;

  always_comb begin
    free_v = ~live;
    old_v  = ~refd;
    if (|same_tag) begin
      sel  = same_tag;
      kind = SLOT_REUSE;
    end else if (|free_v) begin
      sel  = free_v & (~free_v + 1'b1);
      kind = SLOT_FREE;
    end else if (|old_v) begin
      sel  = old_v & (~old_v + 1'b1);
      kind = SLOT_OLD;
    end else begin
      sel  = {{(ENTRIES-1){1'b0}}, 1'b1};
      kind = SLOT_NONE;
    end
  end

  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel));
  p_free_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_FREE) |-> ((sel & live) == '0));
  p_old_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_OLD) |-> ((sel & refd) == '0) && (&live));
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic             lk_write,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rw,
  input  logic             flush
);
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0]             ref_q, ref_d;
  logic [ENTRIES-1:0]             rw_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [ENTRIES-1:0]             lk_match, fill_match, fill_sel, ref_set, ref_acc;
  logic [ENTRIES-1:0]             wr_en;
  slot_kind_e                     fill_kind;
  logic                           any_match, ro_match;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_lk (
    .clk(clk), .rst_n(rst_n), .tag_tab(vpn_q), .live(valid_q),
    .key(lk_vpn), .match(lk_match));

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
    .clk(clk), .rst_n(rst_n), .tag_tab(vpn_q), .live(valid_q),
    .key(fill_vpn), .match(fill_match));

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .same_tag(fill_match), .live(valid_q),
    .refd(ref_q), .sel(fill_sel), .kind(fill_kind));

  // lookup result: one-hot match reduces by OR
  always_comb begin
    lk_ppn   = '0;
    ro_match = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn   = lk_ppn | ppn_q[i];
        ro_match = ro_match | ~rw_q[i];
      end
    end
    any_match = |lk_match;
    lk_fault  = any_match && lk_write && ro_match;
    lk_hit    = any_match && !lk_fault;
  end

  // next state
  always_comb begin
    wr_en   = (fill_en && !flush) ? fill_sel : '0;
    ref_set = (lk_req ? lk_match : '0) | (fill_en ? fill_sel : '0);
    ref_acc = ref_q | ref_set;
    if (flush) begin
      valid_d = '0;
      ref_d   = '0;
    end else begin
      valid_d = valid_q | wr_en;
      ref_d   = (&ref_acc) ? '0 : ref_acc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ref_q   <= ref_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        vpn_q[g] <= fill_vpn;
        ppn_q[g] <= fill_ppn;
        rw_q[g]  <= fill_rw;
      end
    end
  end

  p_hit_fault_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_hit && !lk_fault) |-> (lk_ppn == '0));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0) && (ref_q == '0));
  p_fill_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> ((valid_q & $past(fill_sel)) == $past(fill_sel)));
  p_ref_never_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ref_q));
  p_live_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ($countones(valid_q) >= $countones($past(valid_q))));
endmodule

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb_top;
  localparam int E  = 8;
  localparam int VW = 8;
  localparam int PW = 8;

  logic clk, rst_n;
  logic lk_req, lk_write, fill_en, fill_rw, flush;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [PW-1:0] fill_ppn;
  logic lk_hit, lk_fault;
  logic [PW-1:0] lk_ppn;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic          m_v   [E];
  logic          m_rw  [E];
  logic          m_ref [E];
  logic [VW-1:0] m_vpn [E];
  logic [PW-1:0] m_ppn [E];

  tlb_assoc #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ppn(lk_ppn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_rw(fill_rw), .flush(flush));

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int find(input logic [VW-1:0] v);
    for (int i = 0; i < E; i++) if (m_v[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int pick(input logic [VW-1:0] v);
    int k;
    k = find(v);
    if (k >= 0) return k;
    for (int i = 0; i < E; i++) if (!m_v[i]) return i;
    for (int i = 0; i < E; i++) if (!m_ref[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < E; i++) begin m_v[i] = 0; m_ref[i] = 0; end
  endtask

  // drive one cycle, check outputs, then advance model to post-edge state
  task automatic step(input string tag, input logic rq, input logic wr,
                      input logic [VW-1:0] v, input logic fe,
                      input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                      input logic frw, input logic fl);
    int k, f;
    logic eh, ef;
    logic [PW-1:0] ep;
    bit all1;
    logic nref [E];
    @(negedge clk);
    lk_req = rq; lk_write = wr; lk_vpn = v;
    fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_rw = frw; flush = fl;
    #1;
    k = find(v);
    ef = (k >= 0) && wr && !m_rw[k];
    eh = (k >= 0) && !ef;
    ep = (k >= 0) ? m_ppn[k] : '0;
    n_run++;
    if (lk_hit !== eh || lk_fault !== ef || lk_ppn !== ep) begin
      n_fail++;
      $display("FAIL %s vpn=%0d: hit/fault/ppn actual %b/%b/%0d expected %b/%b/%0d",
               tag, v, lk_hit, lk_fault, lk_ppn, eh, ef, ep);
    end
    if (fl) model_reset();
    else begin
      f = fe ? pick(fv) : -1;
      for (int i = 0; i < E; i++) nref[i] = m_ref[i] | (rq && i == k) | (i == f);
      all1 = 1;
      for (int i = 0; i < E; i++) if (!nref[i]) all1 = 0;
      for (int i = 0; i < E; i++) m_ref[i] = all1 ? 1'b0 : nref[i];
      if (f >= 0) begin
        m_v[f] = 1; m_vpn[f] = fv; m_ppn[f] = fp; m_rw[f] = frw;
      end
    end
  endtask

  task automatic look(input string tag, input logic wr, input logic [VW-1:0] v);
    step(tag, 1'b1, wr, v, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask
  task automatic fill(input string tag, input logic [VW-1:0] v,
                      input logic [PW-1:0] p, input logic rw);
    step(tag, 1'b0, 1'b0, '0, 1'b1, v, p, rw, 1'b0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; lk_req = 0; lk_write = 0; lk_vpn = '0;
    fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_rw = 0; flush = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R9 reset state, R2 miss
    for (int v = 0; v < 4; v++) look("R9", 1'b0, 8'(v));
    // R4 fill into empty slots, R1 any position
    for (int i = 0; i < E - 1; i++) fill("R4", 8'(10 + i), 8'(100 + i), i[0]);
    for (int i = 0; i < E - 1; i++) look("R1", 1'b0, 8'(10 + i));
    // R3 write to read-only (even i stored rw=0) and read/write
    look("R3", 1'b1, 8'd10);
    look("R3", 1'b1, 8'd11);
    // R7 overwrite existing tag
    fill("R7", 8'd12, 8'd200, 1'b1);
    look("R7", 1'b1, 8'd12);
    // last free slot, then R6 ref saturation and R5 victim choice
    fill("R6", 8'd40, 8'd77, 1'b1);
    look("R5", 1'b0, 8'd10);
    look("R5", 1'b0, 8'd11);
    fill("R5", 8'd50, 8'd55, 1'b1);
    look("R5", 1'b0, 8'd50);
    for (int i = 0; i < E - 1; i++) look("R5", 1'b0, 8'(10 + i));
    look("R2", 1'b0, 8'd99);
    // R8 flush beats fill
    step("R8", 1'b1, 1'b0, 8'd10, 1'b1, 8'd60, 8'd66, 1'b1, 1'b1);
    look("R8", 1'b0, 8'd60);
    look("R8", 1'b0, 8'd10);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic fe, fl;
      fe = ($urandom_range(0, 2) == 0);
      fl = ($urandom_range(0, 150) == 0);
      step("R1R5 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           8'($urandom_range(0, 15)), fe, 8'($urandom_range(0, 15)),
           8'($urandom_range(1, 255)), 1'($urandom_range(0, 1)), fl);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule